// File: doc/BRIEF.md
# Crosspoint Switch Matrix with Broadcast Override

This block is a parameterised crosspoint switch. It has `N_IN` data inputs and `N_OUT` data outputs, and every channel is `DW` bits wide. Each output carries the input named by its own select register. Routing is combinational from data input to data output, so a new input value reaches its output in the same cycle.

Select registers are double-buffered. A parallel write port (output index plus input index) fills a shadow bank. The shadow bank is copied into the active bank only on a rising edge of the update control, and only while broadcast is off. All outputs can therefore switch to a new routing together.

A broadcast override sends one chosen input to every output. The update control must stay high for the whole broadcast period. While broadcast is on, the active bank is left untouched. When broadcast ends, the outputs return to the routing they had before it began. A broadcast request made with the update control low is refused, and a registered flag reports it.

Top module: `xpt_matrix`

## Requirements
- R1: While `rst` is high at a clock edge, every select register (shadow and active) is cleared to input 0. After that edge, `bcast_active` and `bcast_err` are 0, and every output carries input 0.
- R2: A configuration write does not change any output until the next update rising edge, meaning `upd` is 1 at a clock edge and was 0 at the previous edge. From the cycle after that edge, the committed routing is visible.
- R3: Routing is combinational. A change on `din` appears on `dout` in the same cycle, with no clock edge in between.
- R4: The data of input i occupies `din[i*DW +: DW]` and output o drives `dout[o*DW +: DW]`. A write with `cfg_we`=1 sets the shadow select of output `cfg_addr` to input `cfg_sel`. A write with `cfg_addr` >= `N_OUT` is ignored.
- R5: If `bcast_req` and `upd` are both 1 at a clock edge while broadcast is off, then from the next cycle `bcast_active` is 1 and every output carries input `bcast_sel`, as sampled at that edge.
- R6: While broadcast is on, changes of `bcast_sel` have no effect on the outputs.
- R7: Broadcast ends in the cycle after an edge at which `bcast_req` or `upd` is 0. The outputs then return to the active routing held before broadcast. No commit takes place, even though `upd` stayed high.
- R8: Configuration writes made during broadcast reach only the shadow bank. They take effect on the next update rising edge after broadcast has ended.
- R9: A request (`bcast_req`=1) at an edge where `upd`=0 starts no broadcast and sets `bcast_err` for the next cycle. `bcast_err` is 0 after any edge without that condition.
- R10: Holding `upd` high commits nothing more after its rising edge. Writes made while it stays high wait for the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Shadow select write strobe |
| cfg_addr | input | ADDR_W | Output index to configure |
| cfg_sel | input | SEL_W | Input index for that output |
| bcast_req | input | 1 | Broadcast request |
| bcast_sel | input | SEL_W | Input to broadcast, sampled at entry |
| upd | input | 1 | Global update control |
| din | input | N_IN*DW | Packed input channels |
| dout | output | N_OUT*DW | Packed output channels |
| bcast_active | output | 1 | Broadcast currently overriding routing |
| bcast_err | output | 1 | Broadcast was requested with update low |

## Verification
The bench targets the restore path:
- Writes made during broadcast must not reach the active bank. A design that commits them, or that commits again when broadcast is released with `upd` still high, shows new routing on exit instead of the old one.
- Holding `upd` high must commit only once. A design that commits on level rather than on the edge lets later writes leak through.
- `bcast_sel` must be latched at entry. A design that follows it live moves every output when `bcast_sel` changes mid-broadcast.
- A request made with `upd` low must be refused. A design that accepts it enters broadcast and leaves `bcast_err` low.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  typedef enum logic {
    BC_IDLE = 1'b0,
    BC_ON   = 1'b1
  } bc_state_e;
endpackage

// File: rtl/xpt_bcast_ctl.sv
module xpt_bcast_ctl
  import xpt_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bcast_req,
  input  logic [SEL_W-1:0] bcast_sel,
  input  logic             upd,
  output logic             commit,
  output logic             bcast_on,
  output logic [SEL_W-1:0] bcast_src,
  output logic             bcast_err
);
  bc_state_e state_q;
  logic      upd_q;
  logic      legal_req;

  assign legal_req = bcast_req & upd;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= BC_IDLE;
      upd_q     <= 1'b0;
      bcast_src <= '0;
      bcast_err <= 1'b0;
    end else begin
      upd_q     <= upd;
      bcast_err <= bcast_req & ~upd;
      case (state_q)
        BC_IDLE: if (legal_req) begin
          state_q   <= BC_ON;
          bcast_src <= bcast_sel;
        end
        BC_ON: if (!legal_req) state_q <= BC_IDLE;
        default: state_q <= BC_IDLE;
      endcase
    end
  end

  assign bcast_on = (state_q == BC_ON);
  assign commit   = upd & ~upd_q & (state_q == BC_IDLE);

  // R7: a low update control always ends the override
  a_r7_drop_when_update_low: assert property (@(posedge clk) disable iff (rst)
    !upd |=> !bcast_on);
  // R9: a request without update raises the flag
  a_r9_flag_illegal_request: assert property (@(posedge clk) disable iff (rst)
    (bcast_req && !upd) |=> (bcast_err && !bcast_on));
  // R6: the broadcast source is held for the whole override
  a_r6_source_held: assert property (@(posedge clk) disable iff (rst)
    bcast_on |=> (!bcast_on || $stable(bcast_src)));
endmodule

// File: rtl/xpt_cfg_bank.sv
module xpt_cfg_bank #(
  parameter int N_IN   = 8,
  parameter int N_OUT  = 6,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [SEL_W-1:0]             wr_sel,
  input  logic                         commit,
  input  logic                         bcast_on,
  output logic [N_OUT-1:0][SEL_W-1:0]  act_sel
);
  logic [N_OUT-1:0][SEL_W-1:0] shadow_q;
  logic                        addr_ok;

  assign addr_ok = ({1'b0, wr_addr} < (ADDR_W+1)'(N_OUT));

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      act_sel  <= '0;
    end else begin
      if (commit) act_sel <= shadow_q;
      for (int o = 0; o < N_OUT; o++) begin
        if (wr_en && addr_ok && (wr_addr == ADDR_W'(o))) shadow_q[o] <= wr_sel;
      end
    end
  end

  // R8: the active bank is frozen while the override runs
  a_r8_active_frozen: assert property (@(posedge clk) disable iff (rst)
    bcast_on |=> $stable(act_sel));
  // R4: an in-range write lands in the shadow bank
  a_r4_shadow_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_ok) |=> (shadow_q[$past(wr_addr)] == $past(wr_sel)));
  // R10: a level-high update never commits twice
  a_r10_single_commit: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);
endmodule

// File: rtl/xpt_route.sv
module xpt_route #(
  parameter int N_IN  = 8,
  parameter int N_OUT = 6,
  parameter int DW    = 4,
  parameter int SEL_W = 3
) (
  input  logic [N_IN*DW-1:0]          din,
  input  logic [N_OUT-1:0][SEL_W-1:0] act_sel,
  input  logic                        bcast_on,
  input  logic [SEL_W-1:0]            bcast_src,
  output logic [N_OUT*DW-1:0]         dout
);
  logic [DW-1:0] din_a [N_IN];

  for (genvar i = 0; i < N_IN; i++) begin : g_unpack
    assign din_a[i] = din[i*DW +: DW];
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [SEL_W-1:0] pick;
    assign pick = bcast_on ? bcast_src : act_sel[o];
    assign dout[o*DW +: DW] = ({1'b0, pick} < (SEL_W+1)'(N_IN)) ? din_a[pick] : '0;

    // R5: during the override every output matches output 0
    always_comb begin
      if (bcast_on) begin
        a_r5_uniform_outputs: assert (dout[o*DW +: DW] == dout[DW-1:0]);
      end
    end
  end
endmodule

// File: rtl/xpt_matrix.sv
module xpt_matrix
  import xpt_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int N_OUT  = 6,
  parameter int DW     = 4,
  parameter int SEL_W  = $clog2(N_IN),
  parameter int ADDR_W = $clog2(N_OUT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic                bcast_req,
  input  logic [SEL_W-1:0]    bcast_sel,
  input  logic                upd,
  input  logic [N_IN*DW-1:0]  din,
  output logic [N_OUT*DW-1:0] dout,
  output logic                bcast_active,
  output logic                bcast_err
);
  logic                        commit;
  logic                        bcast_on;
  logic [SEL_W-1:0]            bcast_src;
  logic [N_OUT-1:0][SEL_W-1:0] act_sel;

  xpt_bcast_ctl #(.SEL_W(SEL_W)) u_ctl (
    .clk(clk), .rst(rst), .bcast_req(bcast_req), .bcast_sel(bcast_sel),
    .upd(upd), .commit(commit), .bcast_on(bcast_on),
    .bcast_src(bcast_src), .bcast_err(bcast_err)
  );

  xpt_cfg_bank #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_sel(cfg_sel),
    .commit(commit), .bcast_on(bcast_on), .act_sel(act_sel)
  );

  xpt_route #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW), .SEL_W(SEL_W)) u_route (
    .din(din), .act_sel(act_sel), .bcast_on(bcast_on),
    .bcast_src(bcast_src), .dout(dout)
  );

  assign bcast_active = bcast_on;

  // R1: nothing is overridden or flagged straight after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!bcast_active && !bcast_err));
endmodule

// File: tb/xpt_matrix_tb.sv
module xpt_matrix_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_IN = 8, N_OUT = 6, DW = 4, SEL_W = 3, ADDR_W = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0, bcast_req = 1'b0, upd = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [SEL_W-1:0] cfg_sel = '0, bcast_sel = '0;
  logic [N_IN*DW-1:0] din = '0;
  logic [N_OUT*DW-1:0] dout;
  logic bcast_active, bcast_err;

  int vectors = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  int m_sh [N_OUT];
  int m_act [N_OUT];
  bit m_bact = 0, m_err = 0, m_upd_q = 0;
  int m_src = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xpt_matrix #(.N_IN(N_IN), .N_OUT(N_OUT), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_sel(cfg_sel),
    .bcast_req(bcast_req), .bcast_sel(bcast_sel), .upd(upd), .din(din),
    .dout(dout), .bcast_active(bcast_active), .bcast_err(bcast_err)
  );

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      foreach (m_sh[o]) begin m_sh[o] = 0; m_act[o] = 0; end
      m_bact = 0; m_err = 0; m_upd_q = 0; m_src = 0;
    end else begin
      if (upd && !m_upd_q && !m_bact) foreach (m_act[o]) m_act[o] = m_sh[o];
      if (cfg_we && int'(cfg_addr) < N_OUT) m_sh[cfg_addr] = int'(cfg_sel);
      m_err = bcast_req && !upd;
      if (!m_bact) begin
        if (bcast_req && upd) begin m_bact = 1; m_src = int'(bcast_sel); end
      end else if (!(bcast_req && upd)) m_bact = 0;
      m_upd_q = upd;
    end
  end

  task automatic tick();
    @(negedge clk);
    din = {$urandom, $urandom};
    #1;
    vectors++;
    for (int o = 0; o < N_OUT; o++) begin
      int idx = m_bact ? m_src : m_act[o];
      logic [DW-1:0] exp_v = din[idx*DW +: DW];
      if (dout[o*DW +: DW] !== exp_v) begin
        fails++;
        $display("FAIL %s out%0d: got %h expected %h", tag, o, dout[o*DW +: DW], exp_v);
      end
    end
    if (bcast_active !== m_bact) begin
      fails++;
      $display("FAIL %s bcast_active: got %b expected %b", tag, bcast_active, m_bact);
    end
    if (bcast_err !== m_err) begin
      fails++;
      $display("FAIL %s bcast_err: got %b expected %b", tag, bcast_err, m_err);
    end
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic wr(int a, int s);
    cfg_we = 1'b1; cfg_addr = ADDR_W'(a); cfg_sel = SEL_W'(s);
    tick();
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    tag = "R1"; ticks(1);
    rst = 1'b0; ticks(2);
    tag = "R3"; ticks(5);                     // R3 new din each cycle, same-cycle check
    tag = "R2";
    for (int o = 0; o < N_OUT; o++) wr(o, (o*3+1) % N_IN);
    tag = "R4"; wr(7, 5); wr(6, 2);           // R4 out-of-range addresses ignored
    tag = "R2"; ticks(2);
    upd = 1'b1; ticks(3);                     // R2 commit on the rising edge
    tag = "R10"; wr(0, 5); wr(3, 7); ticks(3); // R10 held high: no further commit
    upd = 1'b0; ticks(1); upd = 1'b1; ticks(2);
    tag = "R5"; bcast_req = 1'b1; bcast_sel = 3'd6; ticks(3);
    tag = "R6"; bcast_sel = 3'd2; ticks(3);
    tag = "R8"; wr(1, 0); wr(2, 4); ticks(1);
    tag = "R7"; bcast_req = 1'b0; ticks(3);    // R7 restore, upd still high
    tag = "R8"; upd = 1'b0; ticks(1); upd = 1'b1; ticks(2);
    tag = "R7"; bcast_req = 1'b1; bcast_sel = 3'd4; ticks(3);
    upd = 1'b0; ticks(1);
    tag = "R9"; ticks(3); bcast_req = 1'b0; ticks(2);
    tag = "R5"; bcast_req = 1'b1; wr(5, 1); upd = 1'b1; bcast_sel = 3'd7; ticks(3);
    bcast_req = 1'b0; upd = 1'b0; ticks(2);
    tag = "R4";
    for (int k = 0; k < 400; k++) begin
      cfg_we = 1'($urandom); cfg_addr = ADDR_W'($urandom); cfg_sel = SEL_W'($urandom);
      bcast_sel = SEL_W'($urandom);
      if (($urandom % 6) == 0) upd = ~upd;
      if (($urandom % 8) == 0) bcast_req = ~bcast_req;
      tick();
    end
    cfg_we = 1'b0; bcast_req = 1'b0; upd = 1'b0;
    tag = "R1"; rst = 1'b1; ticks(2); rst = 1'b0; ticks(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule